// File: doc/BRIEF.md
# Ultrasonic echo timing controller

This block sits on a simple memory-mapped slave bus and runs one ranging shot of an external ultrasonic transceiver module for each command from software. Software writes a start command into the control register. The block then raises the trigger output for a fixed number of counter-clock cycles. It times how long the echo input stays high, using a counter clocked at 100 MHz, which is twice the 50 MHz bus clock. It then places the result in a read-only count register. Software polls the status register until the busy bit drops, then reads the count. The distance arithmetic is done elsewhere.

Inside, a five-step sequencer (idle, start, count, save, clear) runs in the counter clock domain. The bus-side register file runs in the bus clock domain. Between the two, toggle handshakes carry the start request, the acceptance of that request and the end of a measurement. The echo input passes through a two-flop synchronizer before any logic looks at it. If no echo ends within a full-scale window, the block saves a saturated count and raises a timeout flag.

Top module: `us_echo_timer`

## Requirements
- R1: After reset the trigger output is low and reads of offset 0 (control), offset 1 (status) and offset 2 (count) all return 0.
- R2: A write with data bit 0 set to offset 0, made while status bit 0 (busy) is clear, starts exactly one measurement, and busy reads 1 from the next read onward. A write of 0 to offset 0 starts nothing.
- R3: Control bit 0 reads 1 right after a start write and returns to 0 by itself once the sequencer has taken the command. It reads 0 after the measurement ends.
- R4: Each measurement raises the trigger output once, for exactly TRIG_CYCLES periods of the counter clock.
- R5: The count register receives the number of counter-clock periods between a rising and the following falling edge of the echo input during the counting phase.
- R6: If the echo input is already high when the counting phase begins, that level is ignored. Timing starts only at a later rising edge.
- R7: If the counting phase lasts MAX_COUNT counter-clock periods without an echo falling edge, the count register receives MAX_COUNT and status bit 1 (timeout) is set. The next measurement that ends on a falling edge clears bit 1.
- R8: A start write made while busy is set has no effect: no additional trigger pulse and no additional measurement.
- R9: While a measurement is in progress, the count register keeps returning the result of the previous measurement.
- R10: Consecutive measurements are independent. Each begins from a zero count, so a result never includes cycles from an earlier shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, 50 MHz |
| clk_cnt | input | 1 | Counter clock, 100 MHz, twice the bus clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| bus_addr | input | 2 | Register offset: 0 control, 1 status, 2 count |
| bus_wr | input | 1 | Write strobe, one bus cycle |
| bus_rd | input | 1 | Read strobe; read data is valid on the following cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| trig | output | 1 | Trigger pulse to the transceiver module |
| echo | input | 1 | Echo level from the transceiver module, asynchronous |

## Verification
Two states are hard to reach from the ports. The first is the timeout, which fires only when the counting phase runs the whole window. The bench sets a small MAX_COUNT and reaches the timeout in two ways: by never raising echo, and by raising echo and holding it high. The second is an echo that is already high when counting begins. To reach it, the bench raises echo while the trigger pulse is still high and lowers it a few cycles after the trigger falls. It then checks that only a later, clean pulse is measured. A start write that lands while busy is reached by writing twice in a row before the first echo arrives, and the bench counts trigger pulses at the pin.

// File: rtl/us_echo_pkg.sv
package us_echo_pkg;

    localparam int CNT_W = 32;

    localparam logic [1:0] OFF_CTRL  = 2'd0;
    localparam logic [1:0] OFF_STAT  = 2'd1;
    localparam logic [1:0] OFF_COUNT = 2'd2;

    localparam int STAT_BUSY = 0;
    localparam int STAT_TMO  = 1;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_COUNT = 3'd2,
        ST_SAVE  = 3'd3,
        ST_CLEAR = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic             timeout;
        logic [CNT_W-1:0] value;
    } meas_t;

    function automatic logic edge_of(input logic now_v, input logic prev_v);
        return now_v ^ prev_v;
    endfunction

endpackage

// File: rtl/us_sync.sv
module us_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/us_echo_seq.sv
module us_echo_seq
    import us_echo_pkg::*;
#(
    parameter int TRIG_CYCLES = 1000,
    parameter int MAX_COUNT   = 3800000,
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk_cnt,
    input  logic  rst,
    input  logic  req_tgl,
    input  logic  echo_raw,
    output logic  trig,
    output logic  ack_tgl,
    output logic  done_tgl,
    output meas_t result
);
    localparam int TW = $clog2(TRIG_CYCLES + 1);
    localparam logic [TW-1:0]    TRIG_LAST = TW'(TRIG_CYCLES - 1);
    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(MAX_COUNT - 1);
    localparam logic [CNT_W-1:0] SAT_VAL   = CNT_W'(MAX_COUNT);

    seq_state_t       state, next_state;
    logic             req_s, req_d, start_pulse;
    logic             echo_s, echo_d, rise, seen;
    logic [TW-1:0]    trig_cnt;
    logic [CNT_W-1:0] cnt, wait_cnt;
    logic             tmo_hit, fall_end;

    us_sync #(.STAGES(SYNC_STAGES)) u_req_sync  (.clk(clk_cnt), .rst(rst), .d(req_tgl),  .q(req_s));
    us_sync #(.STAGES(SYNC_STAGES)) u_echo_sync (.clk(clk_cnt), .rst(rst), .d(echo_raw), .q(echo_s));

    assign start_pulse = edge_of(req_s, req_d);
    assign rise        = echo_s & ~echo_d;
    assign fall_end    = seen & ~echo_s;

    always_comb begin
        next_state = state;
        case (state)
            ST_IDLE:  if (start_pulse) next_state = ST_START;
            ST_START: if (trig_cnt == TRIG_LAST) next_state = ST_COUNT;
            ST_COUNT: if (fall_end || wait_cnt == WIN_LAST) next_state = ST_SAVE;
            ST_SAVE:  next_state = ST_CLEAR;
            ST_CLEAR: next_state = ST_IDLE;
            default:  next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_cnt) begin
        if (rst) begin
            state    <= ST_IDLE;
            req_d    <= 1'b0;
            echo_d   <= 1'b0;
            trig     <= 1'b0;
            ack_tgl  <= 1'b0;
            done_tgl <= 1'b0;
            trig_cnt <= '0;
            cnt      <= '0;
            wait_cnt <= '0;
            seen     <= 1'b0;
            tmo_hit  <= 1'b0;
            result   <= '0;
        end else begin
            state  <= next_state;
            req_d  <= req_s;
            echo_d <= echo_s;
            trig   <= (next_state == ST_START);
            case (state)
                ST_IDLE: begin
                    if (start_pulse) ack_tgl <= ~ack_tgl;
                end
                ST_START: begin
                    trig_cnt <= trig_cnt + 1'b1;
                end
                ST_COUNT: begin
                    wait_cnt <= wait_cnt + 1'b1;
                    if ((rise || seen) && echo_s) cnt <= cnt + 1'b1;
                    if (rise) seen <= 1'b1;
                    if (next_state == ST_SAVE) tmo_hit <= ~fall_end;
                end
                ST_SAVE: begin
                    result.timeout <= tmo_hit;
                    result.value   <= tmo_hit ? SAT_VAL : cnt;
                end
                ST_CLEAR: begin
                    cnt      <= '0;
                    wait_cnt <= '0;
                    trig_cnt <= '0;
                    seen     <= 1'b0;
                    done_tgl <= ~done_tgl;
                end
                default: ;
            endcase
        end
    end

    // R2: the sequencer leaves idle only on an accepted start command
    a_r2_idle_hold: assert property (@(posedge clk_cnt) disable iff (rst)
        (state == ST_IDLE && !start_pulse) |=> state == ST_IDLE);

    // R4: the trigger falls only after the full pulse length has elapsed
    a_r4_trig_len: assert property (@(posedge clk_cnt) disable iff (rst)
        $fell(trig) |-> trig_cnt == TW'(TRIG_CYCLES));

    // R10: the clear step leaves a zero counter and returns to idle
    a_r10_clear_zero: assert property (@(posedge clk_cnt) disable iff (rst)
        state == ST_CLEAR |=> (cnt == '0 && wait_cnt == '0 && state == ST_IDLE));

    // R7: the echo counter never passes full scale
    a_r7_cnt_bound: assert property (@(posedge clk_cnt) disable iff (rst)
        cnt <= SAT_VAL);
endmodule

// File: rtl/us_echo_regs.sv
module us_echo_regs
    import us_echo_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        req_tgl,
    input  logic        ack_tgl,
    input  logic        done_tgl,
    input  meas_t       result
);
    logic             ack_s, ack_d, done_s, done_d;
    logic             busy, pend, tmo;
    logic [CNT_W-1:0] cnt_reg;
    logic             start_wr;
    logic             unused_wdata;

    us_sync #(.STAGES(SYNC_STAGES)) u_ack_sync  (.clk(clk), .rst(rst), .d(ack_tgl),  .q(ack_s));
    us_sync #(.STAGES(SYNC_STAGES)) u_done_sync (.clk(clk), .rst(rst), .d(done_tgl), .q(done_s));

    assign start_wr     = bus_wr && bus_addr == OFF_CTRL && bus_wdata[0];
    assign unused_wdata = ^bus_wdata[31:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tgl   <= 1'b0;
            busy      <= 1'b0;
            pend      <= 1'b0;
            tmo       <= 1'b0;
            cnt_reg   <= '0;
            ack_d     <= 1'b0;
            done_d    <= 1'b0;
            bus_rdata <= '0;
        end else begin
            ack_d  <= ack_s;
            done_d <= done_s;
            if (start_wr && !busy) begin
                req_tgl <= ~req_tgl;
                busy    <= 1'b1;
                pend    <= 1'b1;
            end
            if (edge_of(ack_s, ack_d)) pend <= 1'b0;
            if (edge_of(done_s, done_d)) begin
                busy    <= 1'b0;
                cnt_reg <= result.value;
                tmo     <= result.timeout;
            end
            if (bus_rd) begin
                case (bus_addr)
                    OFF_CTRL:  bus_rdata <= {31'd0, pend};
                    OFF_STAT:  bus_rdata <= {30'd0, tmo, busy};
                    OFF_COUNT: bus_rdata <= cnt_reg;
                    default:   bus_rdata <= '0;
                endcase
            end
        end
    end

    // R2: an accepted start write makes the block busy on the next cycle
    a_r2_busy_set: assert property (@(posedge clk) disable iff (rst)
        (start_wr && !busy) |=> busy);

    // R8: start writes while busy send no new request across the clock boundary
    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (busy && start_wr) |=> $stable(req_tgl));

    // R9: the visible count changes only when a measurement completes
    a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !edge_of(done_s, done_d)) |=> $stable(cnt_reg));
endmodule

// File: rtl/us_echo_timer.sv
module us_echo_timer
    import us_echo_pkg::*;
#(
    parameter int TRIG_CYCLES = 1000,
    parameter int MAX_COUNT   = 3800000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        clk_cnt,
    input  logic        rst,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        trig,
    input  logic        echo
);
    logic  req_tgl, ack_tgl, done_tgl;
    meas_t result;

    us_echo_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .req_tgl  (req_tgl),
        .ack_tgl  (ack_tgl),
        .done_tgl (done_tgl),
        .result   (result)
    );

    us_echo_seq #(
        .TRIG_CYCLES(TRIG_CYCLES),
        .MAX_COUNT  (MAX_COUNT),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_seq (
        .clk_cnt (clk_cnt),
        .rst     (rst),
        .req_tgl (req_tgl),
        .echo_raw(echo),
        .trig    (trig),
        .ack_tgl (ack_tgl),
        .done_tgl(done_tgl),
        .result  (result)
    );
endmodule

// File: tb/us_echo_timer_test.sv
`timescale 1ns/1ps
module us_echo_timer_test;
    localparam int TRIG = 50;
    localparam int MAXC = 2000;
    localparam int NV   = 6;
    localparam int VW [NV] = '{1, 2, 9, 128, 777, 1500};
    localparam int VD [NV] = '{3, 4, 10, 2, 50, 7};

    logic        clk = 1'b0, clk_cnt = 1'b0, rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, echo = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        trig;

    int checks = 0, fails = 0;
    int pulses = 0, run = 0, last_w = 0;
    logic trig_prev = 1'b0;
    logic finished = 1'b0;

    always #10 clk = ~clk;
    always #5  clk_cnt = ~clk_cnt;

    us_echo_timer #(.TRIG_CYCLES(TRIG), .MAX_COUNT(MAXC)) uut (
        .clk(clk), .clk_cnt(clk_cnt), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig(trig), .echo(echo)
    );

    always @(negedge clk_cnt) begin
        if (trig) run = run + 1;
        if (trig && !trig_prev) pulses = pulses + 1;
        if (!trig && trig_prev) begin
            last_w = run;
            run = 0;
        end
        trig_prev = trig;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_idle(output logic [31:0] st);
        st = 32'd1;
        for (int i = 0; i < 6000 && st[0]; i++) bus_read(2'd1, st);
    endtask

    task automatic echo_pulse(input int delay, input int width);
        @(negedge clk_cnt);
        repeat (delay) @(negedge clk_cnt);
        echo = 1'b1;
        repeat (width) @(negedge clk_cnt);
        echo = 1'b0;
    endtask

    initial begin
        logic [31:0] v, st;
        int p0;
        repeat (8) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 trig", {31'd0, trig}, 32'd0);
        bus_read(2'd0, v); check("R1 control", v, 32'd0);
        bus_read(2'd1, v); check("R1 status", v, 32'd0);
        bus_read(2'd2, v); check("R1 count", v, 32'd0);

        // R2: writing zero starts nothing
        p0 = pulses;
        bus_write(2'd0, 32'd0);
        repeat (200) @(negedge clk);
        check("R2 no pulse on zero write", pulses, p0);
        bus_read(2'd1, v); check("R2 idle after zero write", v, 32'd0);

        // Vector table: R4, R5, R10 across several echo widths
        for (int k = 0; k < NV; k++) begin
            p0 = pulses;
            bus_write(2'd0, 32'd1);
            wait (trig == 1'b1);
            wait (trig == 1'b0);
            echo_pulse(VD[k], VW[k]);
            wait_idle(st);
            check("R5 status after echo", st, 32'd0);
            bus_read(2'd2, v); check("R5 R10 count equals echo width", v, VW[k]);
            check("R4 one trigger pulse", pulses, p0 + 1);
            check("R4 trigger width", last_w, TRIG);
            bus_read(2'd0, v); check("R3 control cleared", v, 32'd0);
        end

        // R2, R3, R8, R9: busy behaviour
        p0 = pulses;
        bus_write(2'd0, 32'd1);
        bus_read(2'd0, v); check("R3 control set after start", v, 32'd1);
        bus_read(2'd1, v); check("R2 busy after start", v, 32'd1);
        bus_write(2'd0, 32'd1);
        bus_read(2'd2, v); check("R9 previous count while busy", v, 32'd1500);
        wait (trig == 1'b0 && pulses == p0 + 1);
        echo_pulse(5, 33);
        wait_idle(st);
        bus_read(2'd2, v); check("R8 count of single shot", v, 32'd33);
        repeat (300) @(negedge clk);
        check("R8 no extra pulse", pulses, p0 + 1);
        bus_read(2'd1, v); check("R8 idle after ignored start", v, 32'd0);

        // R6: echo already high when counting begins
        bus_write(2'd0, 32'd1);
        wait (trig == 1'b1);
        @(negedge clk_cnt); echo = 1'b1;
        wait (trig == 1'b0);
        repeat (5) @(negedge clk_cnt); echo = 1'b0;
        echo_pulse(10, 40);
        wait_idle(st);
        bus_read(2'd2, v); check("R6 early high level ignored", v, 32'd40);

        // R7: timeout with no echo
        bus_write(2'd0, 32'd1);
        wait_idle(st);
        check("R7 timeout flag no echo", st, 32'd2);
        bus_read(2'd2, v); check("R7 saturated count no echo", v, MAXC);

        // R7: timeout with echo stuck high
        bus_write(2'd0, 32'd1);
        wait (trig == 1'b1);
        wait (trig == 1'b0);
        repeat (3) @(negedge clk_cnt); echo = 1'b1;
        wait_idle(st);
        echo = 1'b0;
        check("R7 timeout flag stuck echo", st, 32'd2);
        bus_read(2'd2, v); check("R7 saturated count stuck echo", v, MAXC);

        // R7: a good measurement clears the flag
        bus_write(2'd0, 32'd1);
        wait (trig == 1'b1);
        wait (trig == 1'b0);
        echo_pulse(4, 10);
        wait_idle(st);
        check("R7 flag cleared", st, 32'd0);
        bus_read(2'd2, v); check("R7 R10 count after timeout", v, 32'd10);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule